// File: doc/BRIEF.md
# Graphic LCD Command and Address Unit

This unit sits between a byte transport and the display RAM of a small graphic LCD controller. Every byte arrives with a flag that marks it as a command or as display data. Command bytes either update the control state or load the column pointer. The control state holds the display mode, the power-down flag and the addressing direction, and the same command also loads the row pointer. Each data byte produces a one-cycle RAM write strobe at the current column and row. The pointer then moves to the next cell, either along the row (horizontal) or down the column (vertical).

The unit also carries out the power-on sequence. An asynchronous power-on reset input holds the sequencer in state `SEQ_WAIT`. After that input is released, the sequencer counts clock edges. Once the required number of edges has passed, it takes the only transition, `SEQ_WAIT -> SEQ_RUN`. While the sequencer is in `SEQ_WAIT`, every byte is ignored and the control state is held at its cleared values. The cleared control state always has power-down set. A power-up therefore always ends in power-down, and firmware must write a control command to wake the display.

The byte decoder sorts each accepted byte into one of four kinds: `BK_NONE`, `BK_CTRL`, `BK_COLUMN` or `BK_DATA`. The address generator acts on that kind. It can load the row or the column, or it can write and advance.

Top module: `lcd_cmd_addr`

## Requirements
- R1: After `por_n` is released, `ready` stays 0 at the first rising clock edge and becomes 1 at the second. A byte presented before `ready` is 1 causes no write and no state change.
- R2: While `ready` is 0, and at the moment it rises, the unit reports `pwr_down`=1, `disp_mode`=00, `vert_addr`=0, `cur_col`=0 and `cur_row`=0.
- R3: A command byte with bit 7 = 0 is a control command. On the next edge it sets the following fields: `disp_mode` = {bit5, bit6}, where 00 is blank, 10 is normal, 01 is all segments on and 11 is inverse video; `pwr_down` = bit4; `vert_addr` = bit3; `cur_row` = bits 2..0. The column is left unchanged.
- R4: A control command whose row field is above 4 sets the row to 4.
- R5: A command byte with bit 7 = 1 loads bits 6..0 into the column on the next edge, and values above 100 load 100. The row and the control state are unchanged.
- R6: An accepted data byte drives `ram_we` high for exactly the following cycle. In that cycle, `ram_col` and `ram_row` show the address held before the byte, and `ram_wdata` shows the byte.
- R7: In horizontal mode (`vert_addr`=0), a data byte increments the column. Column 100 wraps to 0 and increments the row, and row 4 wraps to 0.
- R8: In vertical mode (`vert_addr`=1), a data byte increments the row. Row 4 wraps to 0 and increments the column, and column 100 wraps to 0.
- R9: When `pwr_down` is 1, control commands, column commands and data writes behave exactly as in normal operation.
- R10: A cycle with `in_valid`=0 changes no output state, whatever `in_cmd` and `in_byte` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| in_valid | input | 1 | A byte is presented this cycle |
| in_cmd | input | 1 | 1 = command byte, 0 = display data |
| in_byte | input | 8 | Byte value |
| ready | output | 1 | Power-on sequence complete, bytes accepted |
| pwr_down | output | 1 | Power-down requested (LCD outputs, bias, oscillator off) |
| disp_mode | output | 2 | Display mode, {D,E} encoding |
| vert_addr | output | 1 | 1 = vertical addressing |
| cur_col | output | 7 | Current column pointer (0..100) |
| cur_row | output | 3 | Current row pointer (0..4) |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_col | output | 7 | Column of the write |
| ram_row | output | 3 | Row of the write |
| ram_wdata | output | 8 | Data of the write |

## Verification
The hardest corner to reach is the cell where both pointers wrap together: column 100, row 4, horizontal mode, and the same cell in vertical mode. Writing 505 bytes one at a time would be needed to get there from reset. The stimulus instead uses control and column commands to jump the pointers straight to the last cells. It then issues one or two data bytes and checks that the address wraps to 0/0. The two-edge window just after power-on reset is also narrow. The bench releases `por_n` between edges while presenting a data byte, and checks `ready` and the absence of a write after each of the two edges. It repeats this after a second reset in the middle of the run.

// File: rtl/lcd_cmd_pkg.sv
`timescale 1ns/1ps
package lcd_cmd_pkg;

    // Power-on sequencer states
    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Classification of an accepted byte
    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_CTRL   = 2'd1,
        BK_COLUMN = 2'd2,
        BK_DATA   = 2'd3
    } byte_kind_e;

    // Display mode, encoded as {D,E}
    typedef enum logic [1:0] {
        MODE_BLANK   = 2'b00,
        MODE_ALLON   = 2'b01,
        MODE_NORMAL  = 2'b10,
        MODE_INVERSE = 2'b11
    } disp_mode_e;

    typedef enum logic {
        DIR_HORIZ = 1'b0,
        DIR_VERT  = 1'b1
    } addr_dir_e;

    typedef struct packed {
        disp_mode_e mode;
        logic       pd;
        addr_dir_e  dir;
    } ctrl_t;

    localparam ctrl_t CTRL_CLEARED = '{mode: MODE_BLANK, pd: 1'b1, dir: DIR_HORIZ};

endpackage

// File: rtl/lcd_reset_seq.sv
`timescale 1ns/1ps
module lcd_reset_seq
    import lcd_cmd_pkg::*;
#(
    parameter int SYNC_EDGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic running
);
    localparam int CW = (SYNC_EDGES < 2) ? 1 : $clog2(SYNC_EDGES);
    localparam logic [CW-1:0] LAST = CW'(SYNC_EDGES - 1);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: count edges after release, then run
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_WAIT: begin
                if (cnt_q == LAST) begin
                    state_d = SEQ_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_RUN: begin
                state_d = SEQ_RUN;
            end
            default: state_d = SEQ_WAIT;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_q)
            SEQ_RUN:  running = 1'b1;
            default:  running = 1'b0;
        endcase
    end

    // R1
    ready_after_count_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(running) |-> ($past(cnt_q) == LAST));

    // R1
    run_is_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        running |=> running);

endmodule

// File: rtl/lcd_byte_decode.sv
`timescale 1ns/1ps
module lcd_byte_decode
    import lcd_cmd_pkg::*;
#(
    parameter int COL_MAX = 100,
    parameter int ROW_MAX = 4,
    parameter int COL_W   = 7,
    parameter int ROW_W   = 3
) (
    input  logic              enable,
    input  logic              in_valid,
    input  logic              in_cmd,
    input  logic [7:0]        in_byte,
    output byte_kind_e        kind,
    output ctrl_t             ctrl_val,
    output logic [ROW_W-1:0]  row_val,
    output logic [COL_W-1:0]  col_val
);
    int raw_row;
    int raw_col;

    // Byte classification
    always_comb begin
        kind = BK_NONE;
        if (enable && in_valid) begin
            unique case ({in_cmd, in_byte[7]})
                2'b10:   kind = BK_CTRL;
                2'b11:   kind = BK_COLUMN;
                default: kind = BK_DATA;
            endcase
        end
    end

    // Field extraction with clamping
    always_comb begin
        raw_row  = int'(in_byte[2:0]);
        raw_col  = int'(in_byte[6:0]);
        row_val  = ROW_W'((raw_row > ROW_MAX) ? ROW_MAX : raw_row);
        col_val  = COL_W'((raw_col > COL_MAX) ? COL_MAX : raw_col);
        ctrl_val.mode = disp_mode_e'({in_byte[5], in_byte[6]});
        ctrl_val.pd   = in_byte[4];
        ctrl_val.dir  = in_byte[3] ? DIR_VERT : DIR_HORIZ;
    end

    // R4
    row_clamp_chk: assert final (int'(row_val) <= ROW_MAX);
    // R5
    col_clamp_chk: assert final (int'(col_val) <= COL_MAX);

endmodule

// File: rtl/lcd_addr_gen.sv
`timescale 1ns/1ps
module lcd_addr_gen
    import lcd_cmd_pkg::*;
#(
    parameter int COL_MAX = 100,
    parameter int ROW_MAX = 4,
    parameter int COL_W   = 7,
    parameter int ROW_W   = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr,
    input  byte_kind_e        kind,
    input  logic [ROW_W-1:0]  row_val,
    input  logic [COL_W-1:0]  col_val,
    input  addr_dir_e         dir,
    input  logic [7:0]        wdata,
    output logic [COL_W-1:0]  col_q,
    output logic [ROW_W-1:0]  row_q,
    output logic              we_q,
    output logic [COL_W-1:0]  wcol_q,
    output logic [ROW_W-1:0]  wrow_q,
    output logic [7:0]        wdata_q
);
    localparam logic [COL_W-1:0] COL_END = COL_W'(COL_MAX);
    localparam logic [ROW_W-1:0] ROW_END = ROW_W'(ROW_MAX);

    logic [COL_W-1:0] col_d, col_inc;
    logic [ROW_W-1:0] row_d, row_inc;
    logic             col_last, row_last;

    assign col_last = (col_q == COL_END);
    assign row_last = (row_q == ROW_END);
    assign col_inc  = col_last ? '0 : col_q + 1'b1;
    assign row_inc  = row_last ? '0 : row_q + 1'b1;

    // Next address
    always_comb begin
        col_d = col_q;
        row_d = row_q;
        unique case (kind)
            BK_CTRL:   row_d = row_val;
            BK_COLUMN: col_d = col_val;
            BK_DATA: begin
                if (dir == DIR_HORIZ) begin
                    col_d = col_inc;
                    if (col_last) row_d = row_inc;
                end else begin
                    row_d = row_inc;
                    if (row_last) col_d = col_inc;
                end
            end
            default: ;
        endcase
    end

    // Pointer registers
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (clr) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            col_q <= col_d;
            row_q <= row_d;
        end
    end

    // Write strobe with the pre-increment address
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            we_q    <= 1'b0;
            wcol_q  <= '0;
            wrow_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= (kind == BK_DATA) && !clr;
            if (kind == BK_DATA) begin
                wcol_q  <= col_q;
                wrow_q  <= row_q;
                wdata_q <= wdata;
            end
        end
    end

    // R6
    strobe_follows_data_chk: assert property (@(posedge clk) disable iff (!por_n)
        (kind == BK_DATA && !clr) |=> (we_q && wcol_q == $past(col_q) && wrow_q == $past(row_q)));

    // R7
    horiz_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        (kind == BK_DATA && !clr && dir == DIR_HORIZ && !col_last)
        |=> (col_q == $past(col_q) + 1'b1 && row_q == $past(row_q)));

    // R8
    vert_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        (kind == BK_DATA && !clr && dir == DIR_VERT && !row_last)
        |=> (row_q == $past(row_q) + 1'b1 && col_q == $past(col_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (kind == BK_NONE && !clr) |=> ($stable(col_q) && $stable(row_q) && !we_q));

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        (col_q <= COL_END) && (row_q <= ROW_END));

endmodule

// File: rtl/lcd_cmd_addr.sv
`timescale 1ns/1ps
module lcd_cmd_addr
    import lcd_cmd_pkg::*;
#(
    parameter int COL_MAX    = 100,
    parameter int ROW_MAX    = 4,
    parameter int SYNC_EDGES = 2,
    localparam int COL_W     = $clog2(COL_MAX + 1),
    localparam int ROW_W     = $clog2(ROW_MAX + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             in_valid,
    input  logic             in_cmd,
    input  logic [7:0]       in_byte,
    output logic             ready,
    output logic             pwr_down,
    output logic [1:0]       disp_mode,
    output logic             vert_addr,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row,
    output logic             ram_we,
    output logic [COL_W-1:0] ram_col,
    output logic [ROW_W-1:0] ram_row,
    output logic [7:0]       ram_wdata
);
    logic             running;
    byte_kind_e       kind;
    ctrl_t            dec_ctrl;
    ctrl_t            ctrl_q;
    logic [ROW_W-1:0] dec_row;
    logic [COL_W-1:0] dec_col;

    lcd_reset_seq #(.SYNC_EDGES(SYNC_EDGES)) u_seq (
        .clk     (clk),
        .por_n   (por_n),
        .running (running)
    );

    lcd_byte_decode #(
        .COL_MAX(COL_MAX), .ROW_MAX(ROW_MAX), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_dec (
        .enable   (running),
        .in_valid (in_valid),
        .in_cmd   (in_cmd),
        .in_byte  (in_byte),
        .kind     (kind),
        .ctrl_val (dec_ctrl),
        .row_val  (dec_row),
        .col_val  (dec_col)
    );

    // Control register: cleared to power-down while the sequencer waits
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_q <= CTRL_CLEARED;
        end else if (!running) begin
            ctrl_q <= CTRL_CLEARED;
        end else if (kind == BK_CTRL) begin
            ctrl_q <= dec_ctrl;
        end
    end

    lcd_addr_gen #(
        .COL_MAX(COL_MAX), .ROW_MAX(ROW_MAX), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_addr (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (!running),
        .kind    (kind),
        .row_val (dec_row),
        .col_val (dec_col),
        .dir     (ctrl_q.dir),
        .wdata   (in_byte),
        .col_q   (cur_col),
        .row_q   (cur_row),
        .we_q    (ram_we),
        .wcol_q  (ram_col),
        .wrow_q  (ram_row),
        .wdata_q (ram_wdata)
    );

    assign ready     = running;
    assign pwr_down  = ctrl_q.pd;
    assign disp_mode = ctrl_q.mode;
    assign vert_addr = (ctrl_q.dir == DIR_VERT);

    // R2
    pd_until_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> (pwr_down && disp_mode == 2'b00 && !vert_addr));

    // R1
    no_write_before_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ready |=> !ram_we);

    // R3
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ready && in_valid && in_cmd && !in_byte[7])
        |=> (pwr_down == $past(in_byte[4]) && vert_addr == $past(in_byte[3])
             && disp_mode == {$past(in_byte[5]), $past(in_byte[6])}));

    // R5
    col_cmd_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ready && in_valid && in_cmd && in_byte[7]) |=> ($stable(ctrl_q) && $stable(cur_row)));

endmodule

// File: tb/tb_lcd_cmd_addr.sv
`timescale 1ns/1ps
module tb_lcd_cmd_addr;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       ready, pwr_down, vert_addr, ram_we;
    logic [1:0] disp_mode;
    logic [6:0] cur_col, ram_col;
    logic [2:0] cur_row, ram_row;
    logic [7:0] ram_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcd_cmd_addr dut (
        .clk(clk), .por_n(por_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_byte(in_byte),
        .ready(ready), .pwr_down(pwr_down), .disp_mode(disp_mode), .vert_addr(vert_addr),
        .cur_col(cur_col), .cur_row(cur_row), .ram_we(ram_we), .ram_col(ram_col),
        .ram_row(ram_row), .ram_wdata(ram_wdata)
    );

    typedef struct packed {
        logic       cmd;
        logic [7:0] b;
        logic       we;
        logic [6:0] wc;
        logic [2:0] wr;
        logic [6:0] c;
        logic [2:0] r;
        logic [1:0] m;
        logic       pd;
        logic       v;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h23, 1'b0, 7'd0,   3'd0, 7'd0,   3'd3, 2'b10, 1'b0, 1'b0}, // R3 normal, row 3
        '{1'b1, 8'hE3, 1'b0, 7'd0,   3'd0, 7'd99,  3'd3, 2'b10, 1'b0, 1'b0}, // R5 col 99
        '{1'b0, 8'hA5, 1'b1, 7'd99,  3'd3, 7'd100, 3'd3, 2'b10, 1'b0, 1'b0}, // R7 step
        '{1'b0, 8'h5A, 1'b1, 7'd100, 3'd3, 7'd0,   3'd4, 2'b10, 1'b0, 1'b0}, // R7 col wrap
        '{1'b1, 8'hE4, 1'b0, 7'd0,   3'd0, 7'd100, 3'd4, 2'b10, 1'b0, 1'b0}, // R5 col 100
        '{1'b0, 8'h3C, 1'b1, 7'd100, 3'd4, 7'd0,   3'd0, 2'b10, 1'b0, 1'b0}, // R7 full wrap
        '{1'b1, 8'h6B, 1'b0, 7'd0,   3'd0, 7'd0,   3'd3, 2'b11, 1'b0, 1'b1}, // R3 inverse, vertical
        '{1'b0, 8'h11, 1'b1, 7'd0,   3'd3, 7'd0,   3'd4, 2'b11, 1'b0, 1'b1}, // R8 step
        '{1'b0, 8'h22, 1'b1, 7'd0,   3'd4, 7'd1,   3'd0, 2'b11, 1'b0, 1'b1}, // R8 row wrap
        '{1'b1, 8'hFF, 1'b0, 7'd0,   3'd0, 7'd100, 3'd0, 2'b11, 1'b0, 1'b1}, // R5 clamp 127
        '{1'b1, 8'h0C, 1'b0, 7'd0,   3'd0, 7'd100, 3'd4, 2'b00, 1'b0, 1'b1}, // R3 blank, row 4
        '{1'b0, 8'h33, 1'b1, 7'd100, 3'd4, 7'd0,   3'd0, 2'b00, 1'b0, 1'b1}, // R8 full wrap
        '{1'b1, 8'h0F, 1'b0, 7'd0,   3'd0, 7'd0,   3'd4, 2'b00, 1'b0, 1'b1}, // R4 row 7 clamp
        '{1'b1, 8'h10, 1'b0, 7'd0,   3'd0, 7'd0,   3'd0, 2'b00, 1'b1, 1'b0}, // R9 power-down
        '{1'b0, 8'h44, 1'b1, 7'd0,   3'd0, 7'd1,   3'd0, 2'b00, 1'b1, 1'b0}, // R9 write in PD
        '{1'b1, 8'h40, 1'b0, 7'd0,   3'd0, 7'd1,   3'd0, 2'b01, 1'b0, 1'b0}  // R3 all on
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_cmd   = c;
        in_byte  = b;
        @(posedge clk);
        #2;
    endtask

    task automatic check_cleared(input string tag);
        chk({tag, " R2 pwr_down"}, 32'(pwr_down), 32'd1);
        chk({tag, " R2 disp_mode"}, 32'(disp_mode), 32'd0);
        chk({tag, " R2 vert_addr"}, 32'(vert_addr), 32'd0);
        chk({tag, " R2 cur_col"}, 32'(cur_col), 32'd0);
        chk({tag, " R2 cur_row"}, 32'(cur_row), 32'd0);
    endtask

    task automatic power_up(input string tag);
        // release between edges with a data byte present (R1)
        @(negedge clk);
        por_n    = 1'b1;
        in_valid = 1'b1;
        in_cmd   = 1'b0;
        in_byte  = 8'h99;
        @(posedge clk);
        #2;
        chk({tag, " R1 ready after edge 1"}, 32'(ready), 32'd0);
        chk({tag, " R1 no write edge 1"}, 32'(ram_we), 32'd0);
        @(posedge clk);
        #2;
        chk({tag, " R1 ready after edge 2"}, 32'(ready), 32'd1);
        chk({tag, " R1 no write edge 2"}, 32'(ram_we), 32'd0);
        check_cleared(tag);
        in_valid = 1'b0;
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        chk("R1 ready in reset", 32'(ready), 32'd0);
        check_cleared("in reset");
        power_up("first");

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].cmd, VECS[i].b);
            chk($sformatf("R3/R5/R7/R8 vec%0d cur_col", i), 32'(cur_col), 32'(VECS[i].c));
            chk($sformatf("R3/R4/R7/R8 vec%0d cur_row", i), 32'(cur_row), 32'(VECS[i].r));
            chk($sformatf("R3 vec%0d disp_mode", i), 32'(disp_mode), 32'(VECS[i].m));
            chk($sformatf("R3/R9 vec%0d pwr_down", i), 32'(pwr_down), 32'(VECS[i].pd));
            chk($sformatf("R3 vec%0d vert_addr", i), 32'(vert_addr), 32'(VECS[i].v));
            chk($sformatf("R6 vec%0d ram_we", i), 32'(ram_we), 32'(VECS[i].we));
            if (VECS[i].we) begin
                chk($sformatf("R6 vec%0d ram_col", i), 32'(ram_col), 32'(VECS[i].wc));
                chk($sformatf("R6 vec%0d ram_row", i), 32'(ram_row), 32'(VECS[i].wr));
                chk($sformatf("R6 vec%0d ram_wdata", i), 32'(ram_wdata), 32'(VECS[i].b));
            end
            drive(1'b0, 1'b0, 8'h00);
            chk($sformatf("R6 vec%0d strobe one cycle", i), 32'(ram_we), 32'd0);
        end

        // R10: invalid command and data bytes change nothing
        drive(1'b0, 1'b1, 8'h90);
        drive(1'b0, 1'b1, 8'h1F);
        drive(1'b0, 1'b0, 8'h77);
        chk("R10 cur_col held", 32'(cur_col), 32'd1);
        chk("R10 cur_row held", 32'(cur_row), 32'd0);
        chk("R10 pwr_down held", 32'(pwr_down), 32'd0);
        chk("R10 disp_mode held", 32'(disp_mode), 32'b01);
        chk("R10 no write", 32'(ram_we), 32'd0);

        // R6/R7: back-to-back data bytes, horizontal
        drive(1'b1, 1'b0, 8'hC1);
        chk("R6 b2b first we", 32'(ram_we), 32'd1);
        chk("R6 b2b first col", 32'(ram_col), 32'd1);
        drive(1'b1, 1'b0, 8'hC2);
        chk("R6 b2b second we", 32'(ram_we), 32'd1);
        chk("R6 b2b second col", 32'(ram_col), 32'd2);
        chk("R6 b2b second data", 32'(ram_wdata), 32'hC2);
        chk("R7 b2b cur_col", 32'(cur_col), 32'd3);
        drive(1'b0, 1'b0, 8'h00);

        // Reset in the middle of operation
        @(negedge clk);
        por_n = 1'b0;
        #2;
        chk("R1 ready drops", 32'(ready), 32'd0);
        check_cleared("mid reset");
        repeat (2) @(posedge clk);
        power_up("second");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule